// File: doc/BRIEF.md
# Filter Multiply-Accumulate Engine

This block is a fixed-point filter accelerator. It owns a small local memory of 16-bit words and divides it into three circular areas: one holds incoming samples, one holds coefficients and one holds results. A single multiply-accumulate datapath is reused, one tap per clock, for either a finite impulse response filter or an unfolded direct-form-1 recursive filter. Each area is placed by a base address and a size, and all addressing inside an area wraps around that area.

A function code, applied with a one-cycle `start` pulse, selects what the engine does next. It can seed the sample area, the coefficient area or the result area through the write-data port, or it can run one of the two filters. During a filter run every accepted sample can release a new output. That output is computed only when enough history is present and room is left for the result. Results are then scaled by a programmable left shift, optionally saturated and queued for the read port. Two watermark flags tell the surrounding logic when the sample area is nearly full and when too few results are waiting. Two sticky error flags record a write with no room and a read with nothing to read.

Top module: `fmac_engine`

## Requirements
- R1: Each area is circular. An offset that reaches the area size returns to 0, and the memory address is (base + offset) modulo the memory depth, so an area may run past the top of memory.
- R2: Function code 2 stores P + Q write-data words at consecutive addresses from the coefficient base (P feed-forward words, then Q feedback words). The first word of each group multiplies the oldest sample of its history.
- R3: Function code 1 empties the sample area and then accepts P samples. Function code 3 empties the result area and then stores P history words there; these words are never returned on the read port.
- R4: In filter mode (code 4) an output is produced when at least P samples are held and fewer unread results than the result-area size exist. The output is the sum of P coefficient-sample products over the oldest P samples, and producing it consumes the oldest sample.
- R5: In recursive mode (code 5) the sum also adds Q feedback products of the feedback coefficients with the Q most recent outputs, oldest first, and each new output joins that history.
- R6: The output is (accumulator << R) >> 15 with arithmetic truncation, taken over a 40-bit accumulator.
- R7: With clipping on, an output above 32767 or below -32768 is held at that limit; with clipping off the low 16 bits are kept.
- R8: `x1_full` is 1 while the free sample slots are fewer than 2^`x1_wm` (1, 2, 4 or 8).
- R9: `y_empty` is 1 while the unread results are fewer than 2^`y_wm`.
- R10: A sample write with no free sample slot is dropped and sets `ovf_flag`; both error flags clear on every `start`.
- R11: A read with no unread result returns 0 and sets `unf_flag`.
- R12: After reset the read data and both error flags are 0 and no function is active; a write while no function is active changes nothing.
- R13: `rd_data` holds the oldest unread result one cycle after `rd_req`, and results come out in the order they were made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the function in `func` |
| func | input | 3 | 0 none, 1 seed samples, 2 seed coefficients, 3 seed results, 4 FIR, 5 recursive |
| prm_p | input | 8 | P: word count or feed-forward tap count |
| prm_q | input | 8 | Q: feedback word or tap count |
| prm_r | input | 3 | R: left shift applied to the accumulator |
| clip_en | input | 1 | Saturate outputs when 1 |
| x1_base | input | 8 | Sample area base address |
| x1_size | input | 8 | Sample area size in words |
| x2_base | input | 8 | Coefficient area base address |
| y_base | input | 8 | Result area base address |
| y_size | input | 8 | Result area size in words |
| x1_wm | input | 2 | Sample full threshold code |
| y_wm | input | 2 | Result empty threshold code |
| wr_en | input | 1 | Write-data strobe |
| wr_data | input | 16 | Write data |
| rd_req | input | 1 | Read strobe |
| rd_data | output | 16 | Read data |
| x1_full | output | 1 | Sample area watermark flag |
| y_empty | output | 1 | Result area watermark flag |
| ovf_flag | output | 1 | Sticky write-without-room flag |
| unf_flag | output | 1 | Sticky read-while-empty flag |

## Verification
A wrong read or write pointer shows up as a wrong value on `rd_data` at the very next result, since every output depends on the exact contents and order of the sample and feedback histories. A wrong occupancy count moves `x1_full` or `y_empty` away from the threshold in the cycle after the write or read that caused it, or makes an output appear early or never. Asymmetric coefficients make a reversed tap order visible on the first output, and the recursive runs carry any single wrong result into every later output.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
   typedef enum logic [2:0] {
      FN_IDLE  = 3'd0,
      FN_LD_X1 = 3'd1,
      FN_LD_X2 = 3'd2,
      FN_LD_Y  = 3'd3,
      FN_FIR   = 3'd4,
      FN_IIR   = 3'd5
   } fn_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_TAP  = 2'd1,
      PH_WB   = 2'd2
   } ph_e;
endpackage

// File: rtl/fmac_store.sv
module fmac_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 256,
   parameter int NRD   = 3,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wa_en,
   input  logic [AW-1:0]     wa_adr,
   input  logic [DW-1:0]     wa_dat,
   input  logic              wb_en,
   input  logic [AW-1:0]     wb_adr,
   input  logic [DW-1:0]     wb_dat,
   input  logic [NRD*AW-1:0] rd_adr,
   output logic [NRD*DW-1:0] rd_dat
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("fmac_store: DEPTH must be a power of two");
   end

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wa_en) cells[wa_adr] <= wa_dat;
      if (wb_en) cells[wb_adr] <= wb_dat;
   end

   for (genvar i = 0; i < NRD; i++) begin : g_rd
      assign rd_dat[i*DW +: DW] = cells[rd_adr[i*AW +: AW]];
   end
endmodule

// File: rtl/fmac_mac.sv
module fmac_mac #(
   parameter int DW    = 16,
   parameter int ACC_W = 40,
   parameter int RW    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic signed [DW-1:0] opa,
   input  logic signed [DW-1:0] opb,
   input  logic [RW-1:0]        shift,
   input  logic                 clip,
   output logic [DW-1:0]        res
);
   localparam int GW = ACC_W - 2*DW;
   localparam int EW = ACC_W + (1 << RW);
   localparam logic signed [EW-1:0] MAXV = EW'((2**(DW-1)) - 1);
   localparam logic signed [EW-1:0] MINV = -MAXV - EW'(1);

   if (GW < 1) begin : g_bad_acc
      $error("fmac_mac: ACC_W needs guard bits above the product width");
   end

   logic signed [ACC_W-1:0]  acc;
   logic signed [2*DW-1:0]   prod;
   logic signed [EW-1:0]     ext, shl, qv;

   assign prod = opa * opb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc + {{GW{prod[2*DW-1]}}, prod};
   end

   always_comb begin
      ext = {{(EW-ACC_W){acc[ACC_W-1]}}, acc};
      shl = ext <<< shift;
      qv  = shl >>> (DW-1);
      if (clip && (qv > MAXV))      res = MAXV[DW-1:0];
      else if (clip && (qv < MINV)) res = MINV[DW-1:0];
      else                          res = qv[DW-1:0];
   end
endmodule

// File: rtl/fmac_engine.sv
module fmac_engine
   import fmac_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 256,
   parameter int ACC_W = 40,
   parameter int RW    = 3,
   parameter int PW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    func,
   input  logic [PW-1:0] prm_p,
   input  logic [PW-1:0] prm_q,
   input  logic [RW-1:0] prm_r,
   input  logic          clip_en,
   input  logic [AW-1:0] x1_base,
   input  logic [AW-1:0] x1_size,
   input  logic [AW-1:0] x2_base,
   input  logic [AW-1:0] y_base,
   input  logic [AW-1:0] y_size,
   input  logic [1:0]    x1_wm,
   input  logic [1:0]    y_wm,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_req,
   output logic [DW-1:0] rd_data,
   output logic          x1_full,
   output logic          y_empty,
   output logic          ovf_flag,
   output logic          unf_flag
);
   localparam int CW = AW + 1;
   localparam int SW = AW + 2;

   if (PW > AW) begin : g_bad_pw
      $error("fmac_engine: PW must not exceed the address width");
   end

   fn_e           mode, st_fn;
   ph_e           ph;
   logic [PW-1:0] p_r, q_r;
   logic [RW-1:0] r_r;
   logic          clip_r;
   logic [AW-1:0] x1_wp, x1_rp, y_wp;
   logic [CW-1:0] x1_cnt, y_cnt, ld_idx, tap;

   function automatic logic [AW-1:0] ring_inc(input logic [AW-1:0] off, input logic [AW-1:0] sz);
      logic [CW-1:0] n;
      n = {1'b0, off} + CW'(1);
      return (n >= {1'b0, sz}) ? '0 : n[AW-1:0];
   endfunction

   function automatic logic [AW-1:0] ring_fold(input logic [SW-1:0] s, input logic [AW-1:0] sz);
      logic [SW-1:0] d;
      d = s - {2'b0, sz};
      return (s >= {2'b0, sz}) ? d[AW-1:0] : s[AW-1:0];
   endfunction

   // ---------------- control decode ----------------
   logic          is_filt, is_load, x1_space, x1_acc, push, ld2, ldy, ld_any;
   logic          mac_go, wbw, rd_pop, in_x1;
   logic [CW-1:0] tot, ld_tot, st_tot, x1_free;
   logic [AW-1:0] x1_off, yh_off, rd_off;
   logic [DW-1:0] mac_res, coef_w, dat_w, rd_w;
   logic [SW-1:0] yh_sum;

   always_comb begin
      st_fn = (func <= 3'd5) ? fn_e'(func) : FN_IDLE;
      st_tot = CW'(prm_p) + ((st_fn == FN_LD_X2) ? CW'(prm_q) : '0);
      if ((st_fn == FN_LD_X1 || st_fn == FN_LD_X2 || st_fn == FN_LD_Y) && st_tot == '0)
         st_fn = FN_IDLE;
   end

   assign is_filt  = (mode == FN_FIR) || (mode == FN_IIR);
   assign is_load  = (mode == FN_LD_X1) || (mode == FN_LD_X2) || (mode == FN_LD_Y);
   assign tot      = CW'(p_r) + ((mode == FN_IIR) ? CW'(q_r) : '0);
   assign ld_tot   = CW'(p_r) + ((mode == FN_LD_X2) ? CW'(q_r) : '0);
   assign x1_space = x1_cnt < {1'b0, x1_size};
   assign x1_acc   = wr_en && !start && (mode == FN_LD_X1 || is_filt);
   assign push     = x1_acc && x1_space;
   assign ld2      = wr_en && !start && (mode == FN_LD_X2);
   assign ldy      = wr_en && !start && (mode == FN_LD_Y);
   assign ld_any   = wr_en && !start && is_load;
   assign mac_go   = (ph == PH_IDLE) && is_filt && !start && (p_r != '0)
                     && (x1_cnt >= CW'(p_r)) && (y_cnt < {1'b0, y_size});
   assign wbw      = (ph == PH_WB) && !start;
   assign rd_pop   = rd_req && (y_cnt != '0);

   // ---------------- circular addressing ----------------
   assign in_x1  = tap < CW'(p_r);
   assign x1_off = ring_fold({2'b0, x1_rp} + {1'b0, tap}, x1_size);
   assign yh_sum = {2'b0, y_wp} + {2'b0, y_size} - SW'(q_r) + SW'(tap - CW'(p_r));
   assign yh_off = ring_fold(yh_sum, y_size);
   assign rd_off = ring_fold({2'b0, y_wp} + {2'b0, y_size} - {1'b0, y_cnt}, y_size);

   logic [3*AW-1:0] rd_adr;
   logic [3*DW-1:0] rd_dat;
   logic            wa_en;
   logic [AW-1:0]   wa_adr;

   assign rd_adr = {y_base + rd_off,
                    in_x1 ? (x1_base + x1_off) : (y_base + yh_off),
                    x2_base + tap[AW-1:0]};
   assign coef_w = rd_dat[0 +: DW];
   assign dat_w  = rd_dat[DW +: DW];
   assign rd_w   = rd_dat[2*DW +: DW];
   assign wa_en  = push || ld2 || ldy;
   assign wa_adr = ld2 ? (x2_base + ld_idx[AW-1:0]) :
                   ldy ? (y_base + y_wp) : (x1_base + x1_wp);

   fmac_store #(.DW(DW), .DEPTH(DEPTH), .NRD(3)) u_store (
      .clk    (clk),
      .wa_en  (wa_en),
      .wa_adr (wa_adr),
      .wa_dat (wr_data),
      .wb_en  (wbw),
      .wb_adr (y_base + y_wp),
      .wb_dat (mac_res),
      .rd_adr (rd_adr),
      .rd_dat (rd_dat)
   );

   fmac_mac #(.DW(DW), .ACC_W(ACC_W), .RW(RW)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mac_go),
      .en    (ph == PH_TAP),
      .opa   ($signed(coef_w)),
      .opb   ($signed(dat_w)),
      .shift (r_r),
      .clip  (clip_r),
      .res   (mac_res)
   );

   // ---------------- state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= FN_IDLE;  ph <= PH_IDLE;
         p_r <= '0; q_r <= '0; r_r <= '0; clip_r <= 1'b0;
         x1_wp <= '0; x1_rp <= '0; x1_cnt <= '0;
         y_wp <= '0; y_cnt <= '0; ld_idx <= '0; tap <= '0;
         rd_data <= '0; ovf_flag <= 1'b0; unf_flag <= 1'b0;
      end else begin
         if (rd_req) begin
            rd_data <= rd_pop ? rd_w : '0;
            if (!rd_pop) unf_flag <= 1'b1;
         end
         if (start) begin
            mode <= st_fn;  ph <= PH_IDLE;  tap <= '0;  ld_idx <= '0;
            p_r <= prm_p; q_r <= prm_q; r_r <= prm_r; clip_r <= clip_en;
            ovf_flag <= 1'b0;  unf_flag <= 1'b0;
            if (st_fn == FN_LD_X1) begin
               x1_wp <= '0; x1_rp <= '0; x1_cnt <= '0;
            end
            if (st_fn == FN_LD_Y) begin
               y_wp <= '0; y_cnt <= '0;
            end else begin
               y_cnt <= y_cnt - CW'(rd_pop);
            end
         end else begin
            if (x1_acc && !x1_space) ovf_flag <= 1'b1;
            if (push) x1_wp <= ring_inc(x1_wp, x1_size);
            x1_cnt <= x1_cnt + CW'(push) - CW'(wbw);
            if (ld_any) begin
               ld_idx <= ld_idx + CW'(1);
               if (ld_idx + CW'(1) == ld_tot) mode <= FN_IDLE;
            end
            if (ldy || wbw) y_wp <= ring_inc(y_wp, y_size);
            y_cnt <= y_cnt + CW'(wbw) - CW'(rd_pop);
            unique case (ph)
               PH_IDLE: if (mac_go) begin ph <= PH_TAP; tap <= '0; end
               PH_TAP:  if (tap + CW'(1) == tot) ph <= PH_WB; else tap <= tap + CW'(1);
               PH_WB: begin
                  ph    <= PH_IDLE;
                  x1_rp <= ring_inc(x1_rp, x1_size);
               end
               default: ph <= PH_IDLE;
            endcase
         end
      end
   end

   assign x1_free = {1'b0, x1_size} - x1_cnt;
   assign x1_full = x1_free < (CW'(1) << x1_wm);
   assign y_empty = y_cnt < (CW'(1) << y_wm);

   // ---------------- assertions ----------------
   AST_X1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      x1_cnt <= {1'b0, x1_size}) else $error("sample count above area size"); // R4
   AST_Y_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WB) |-> (y_cnt < {1'b0, y_size})) else $error("result written over unread data"); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (x1_acc && !x1_space) |=> ovf_flag) else $error("dropped write not flagged"); // R10
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && (y_cnt == '0) && !start) |=> ((rd_data == '0) && unf_flag)) else $error("empty read wrong"); // R11
   AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!ovf_flag && !unf_flag)) else $error("flags not cleared by start"); // R10
endmodule

// File: tb/fmac_engine_tb.sv
module fmac_engine_tb;
   import fmac_pkg::*;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, start, clip_en, wr_en, rd_req;
   logic [2:0]  func, prm_r;
   logic [7:0]  prm_p, prm_q, x1_base, x1_size, x2_base, y_base, y_size;
   logic [1:0]  x1_wm, y_wm;
   logic [15:0] wr_data, rd_data;
   logic        x1_full, y_empty, ovf_flag, unf_flag;

   fmac_engine u_dut (.*);

   int compared = 0, mismatched = 0;
   int xs [64];
   int ys [64];
   int cf [16];
   int xn, yn, on_;

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic go(fn_e fn, int p, int q, int r, bit clip);
      func = fn; prm_p = 8'(p); prm_q = 8'(q); prm_r = 3'(r); clip_en = clip;
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic wr(logic [15:0] d);
      wr_en = 1'b1; wr_data = d; @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(output logic [15:0] v);
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0; v = rd_data;
   endtask

   function automatic logic [15:0] scale(longint acc, int r, bit clip);
      longint w;
      w = (acc <<< r) >>> 15;
      if (clip && w > 32767)  return 16'h7FFF;
      if (clip && w < -32768) return 16'h8000;
      return w[15:0];
   endfunction

   // expected next output; nq feedback taps follow np feed-forward taps in cf[]
   function automatic logic [15:0] model(int np, int nq, int r, bit clip);
      longint acc = 0;
      for (int k = 0; k < np; k++) acc += longint'(cf[k]) * longint'(xs[on_ + k]);
      for (int j = 0; j < nq; j++) acc += longint'(cf[np + j]) * longint'(ys[yn - nq + j]);
      return scale(acc, r, clip);
   endfunction

   task automatic setup(int np, int nq, bit rand_c, int cmask);
      go(FN_LD_X2, np, nq, 0, 0);
      for (int k = 0; k < np + nq; k++) begin
         if (rand_c) cf[k] = int'($signed(16'($urandom) & 16'(cmask))) ;
         wr(16'(cf[k]));
      end
      go(FN_LD_X1, np - 1, 0, 0, 0);
      xn = 0; on_ = 0; yn = 0;
      for (int k = 0; k < np - 1; k++) begin wr(16'h0); xs[xn++] = 0; end
      if (nq > 0) begin
         go(FN_LD_Y, nq, 0, 0, 0);
         for (int k = 0; k < nq; k++) begin wr(16'h0); ys[yn++] = 0; end
      end
   endtask

   task automatic step(string tag, logic [15:0] d, int np, int nq, int r, bit clip);
      logic [15:0] v, e;
      wr(d); xs[xn++] = int'($signed(d));
      tick(np + nq + 5);
      chk({tag, " y_empty"}, {15'b0, y_empty}, 16'h0);
      rd(v);
      e = model(np, nq, r, clip);
      chk(tag, v, e);
      on_++;
      ys[yn++] = int'($signed(e));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL R12 watchdog actual=expired expected=finished");
      report();
      $finish;
   end

   initial begin
      logic [15:0] v, e1;
      void'($urandom(32'd4711));
      rst_n = 1'b0; start = 0; func = 0; prm_p = 0; prm_q = 0; prm_r = 0; clip_en = 0;
      wr_en = 0; wr_data = 0; rd_req = 0;
      x1_base = 8'd250; x1_size = 8'd12; x2_base = 8'd100;
      y_base = 8'd40; y_size = 8'd8; x1_wm = 0; y_wm = 0;
      tick(3); rst_n = 1'b1; tick(1);

      // R12 reset state
      chk("R12 rd_data", rd_data, 16'h0);
      chk("R12 ovf", {15'b0, ovf_flag}, 16'h0);
      chk("R12 unf", {15'b0, unf_flag}, 16'h0);
      chk("R9 y_empty at reset", {15'b0, y_empty}, 16'h1);

      // R12 write with no function is ignored (R8 threshold 8 on size 8)
      x1_size = 8'd8; x1_wm = 2'd3; tick(1);
      chk("R8 x1_full free=8", {15'b0, x1_full}, 16'h0);
      wr(16'h1234); tick(2);
      chk("R12 idle write ignored", {15'b0, x1_full}, 16'h0);
      chk("R12 idle write no ovf", {15'b0, ovf_flag}, 16'h0);
      x1_size = 8'd12; x1_wm = 2'd0;

      // R11 underflow, R10 start clears
      rd(v);
      chk("R11 empty read data", v, 16'h0);
      chk("R11 unf set", {15'b0, unf_flag}, 16'h1);
      go(FN_IDLE, 0, 0, 0, 0);
      chk("R10 start clears unf", {15'b0, unf_flag}, 16'h0);

      // R2 tap order directed: oldest sample uses first coefficient
      cf[0] = 16'h2000; cf[1] = 16'h4000;
      setup(2, 0, 0, 0);
      go(FN_FIR, 2, 0, 0, 1);
      wr(16'h4000); tick(8); rd(v); chk("R2 first out", v, 16'h2000);
      wr(16'h0000); tick(8); rd(v); chk("R2 second out", v, 16'h1000);

      // R7 saturation directed
      cf[0] = 16'h7FFF; cf[1] = 16'h7FFF;
      setup(2, 0, 0, 0);
      go(FN_FIR, 2, 0, 0, 1);
      wr(16'h7FFF); tick(8); rd(v); chk("R7 no clip needed", v, 16'h7FFE);
      wr(16'h7FFF); tick(8); rd(v); chk("R7 clip high", v, 16'h7FFF);

      // R4 gating: P-1 samples give no output
      setup(4, 0, 1, 16'hFFFF);
      tick(10);
      chk("R4 gated with P-1 samples", {15'b0, y_empty}, 16'h1);
      go(FN_FIR, 4, 0, 0, 1);
      for (int i = 0; i < 20; i++) step("R4 R1 fir clip", 16'($urandom), 4, 0, 0, 1);

      // R6 R7 shift and wrap
      setup(3, 0, 1, 16'hFFFF);
      go(FN_FIR, 3, 0, 1, 0);
      for (int i = 0; i < 14; i++) step("R6 R7 fir wrap", 16'($urandom), 3, 0, 1, 0);

      // R9 R13 two results queued, read in order
      y_wm = 2'd1;
      wr(16'h1111); xs[xn++] = 16'h1111; tick(9);
      chk("R9 one unread below 2", {15'b0, y_empty}, 16'h1);
      wr(16'h2222); xs[xn++] = 16'h2222; tick(9);
      chk("R9 two unread", {15'b0, y_empty}, 16'h0);
      e1 = model(3, 0, 1, 0); on_++;
      rd(v); chk("R13 first in order", v, e1);
      e1 = model(3, 0, 1, 0); on_++;
      rd(v); chk("R13 second in order", v, e1);
      y_wm = 2'd0;

      // R8 R10 sample area overflow
      go(FN_LD_X1, 20, 0, 0, 0);
      x1_wm = 2'd2;
      for (int i = 0; i < 8; i++) wr(16'(i));
      chk("R8 free=4 thr=4", {15'b0, x1_full}, 16'h0);
      wr(16'h8); chk("R8 free=3 thr=4", {15'b0, x1_full}, 16'h1);
      x1_wm = 2'd0;
      wr(16'h9); wr(16'hA);
      chk("R8 free=1 thr=1", {15'b0, x1_full}, 16'h0);
      wr(16'hB);
      chk("R8 free=0", {15'b0, x1_full}, 16'h1);
      chk("R10 no ovf yet", {15'b0, ovf_flag}, 16'h0);
      wr(16'hC);
      chk("R10 ovf on full write", {15'b0, ovf_flag}, 16'h1);

      // R3 R5 recursive filter
      setup(3, 2, 1, 16'h0FFF);
      for (int k = 0; k < 5; k++) cf[k] = (cf[k] >= 2048) ? cf[k] - 4096 : cf[k];
      go(FN_LD_X2, 3, 2, 0, 0);
      for (int k = 0; k < 5; k++) wr(16'(cf[k]));
      tick(10);
      chk("R3 seeded history not readable", {15'b0, y_empty}, 16'h1);
      go(FN_IIR, 3, 2, 1, 1);
      for (int i = 0; i < 16; i++) step("R5 iir", 16'($urandom), 3, 2, 1, 1);

      report();
      $finish;
   end
endmodule